// File: doc/BRIEF.md
# Warp Atomic Combining Unit

This block takes one batch of atomic read-modify-write requests from a 32-lane warp and carries them out against a shared word-addressed memory. Each lane supplies a valid bit, a word address, a 3-bit opcode and an operand. The unit gathers the lanes that name the same address into one group. It reads that word once and applies the group's updates one per cycle in ascending lane order inside the unit. It then writes the final value back once. Each lane receives the value its address held just before its own update was applied.

Two execution slots work on different address groups at the same time. Each slot has its own fixed-latency memory port, with a read request, a read-data strobe, a write request and a write acknowledge. The batch is accepted with a valid/ready handshake. A single batch-done response carries all 32 returned values. That response is raised only after every group's write has been acknowledged. No new batch is taken until the response has been consumed, so no other path can write these words while a batch is in progress.

Top module: `warp_atomic_combiner`

## Requirements
- R1: `req_ready` is high after reset and whenever no batch is in progress. A batch is taken on a cycle with `req_valid` and `req_ready` both high. `req_ready` then stays low until the cycle after `rsp_valid` and `rsp_ready` are both high.
- R2: Lanes sharing an address update that word in ascending lane index order. Each valid lane's response equals the word's value just before its own update, so the results match a model that processes the valid lanes one after another from lane 0 to lane 31.
- R3: The opcode encodings are 0 add (wrapping), 1 unsigned minimum, 2 unsigned maximum, 3 exchange, 4 bitwise and, 5 bitwise or and 6 bitwise xor. Code 7 leaves the word unchanged and still returns its value.
- R4: Each distinct address among the valid lanes gets exactly one memory read and one memory write per batch. On each slot, every write is preceded by exactly one read. When all 32 lanes name one address, the batch makes a single write.
- R5: A write carries the group's final value, so after the batch, memory equals the sequential model's result and no intermediate value is ever written.
- R6: Groups with different addresses run concurrently on the two slots. When a batch has all-distinct addresses, both slots have memory operations outstanding at the same time.
- R7: A lane with its valid bit clear does not change memory, and its response word is zero.
- R8: `rsp_valid` stays high and `rsp_data` stays stable until `rsp_ready` is seen high.
- R9: While no batch is in progress, no memory read or write is issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Batch offered |
| req_ready | output | 1 | Unit can take a batch |
| req_lane_valid | input | LANES | Per-lane participation bits |
| req_addr | input | LANES*AW | Per-lane word address, lane i at bits [i*AW +: AW] |
| req_op | input | LANES*3 | Per-lane opcode, lane i at bits [i*3 +: 3] |
| req_data | input | LANES*DW | Per-lane operand, lane i at bits [i*DW +: DW] |
| rsp_valid | output | 1 | Batch results ready |
| rsp_ready | input | 1 | Consumer takes the results |
| rsp_data | output | LANES*DW | Per-lane returned old value, lane i at bits [i*DW +: DW] |
| mem_rd_en | output | SLOTS | One-cycle read request per slot |
| mem_wr_en | output | SLOTS | One-cycle write request per slot |
| mem_addr | output | SLOTS*AW | Per-slot word address |
| mem_wdata | output | SLOTS*DW | Per-slot write data |
| mem_rvalid | input | SLOTS | Per-slot read data strobe |
| mem_rdata | input | SLOTS*DW | Per-slot read data |
| mem_wack | input | SLOTS | Per-slot write acknowledge |

## Verification
The assertions cover the handshake rules on every cycle: ready stays low under a pending response, the response holds steady under backpressure, and the memory stays silent while idle. They also check that each slot alternates strictly between reads and writes, that two slots never write one address together, and that a batch never writes more words than it had valid lanes. Only the bench scenarios can show that the returned values and final memory contents match sequential lane-order semantics for every opcode. The same holds for the exact write count per distinct address, full contention collapsing to one write, and the two slots overlapping when addresses are all distinct.

// File: rtl/wac_pkg.sv
package wac_pkg;
   typedef enum logic [2:0] {
      OP_ADD  = 3'd0,
      OP_MINU = 3'd1,
      OP_MAXU = 3'd2,
      OP_XCHG = 3'd3,
      OP_AND  = 3'd4,
      OP_OR   = 3'd5,
      OP_XOR  = 3'd6,
      OP_NOP  = 3'd7
   } wac_op_e;

   typedef enum logic [2:0] {
      S_IDLE, S_RREQ, S_RWAIT, S_UPD, S_WREQ, S_WWAIT
   } wac_slot_st_e;
endpackage

// File: rtl/wac_alu.sv
module wac_alu #(
   parameter int DW = 32
) (
   input  logic [2:0]    op,
   input  logic [DW-1:0] cur,
   input  logic [DW-1:0] opnd,
   output logic [DW-1:0] nxt
);
   import wac_pkg::*;

   always_comb begin
      unique case (wac_op_e'(op))
         OP_ADD:  nxt = cur + opnd;
         OP_MINU: nxt = (opnd < cur) ? opnd : cur;
         OP_MAXU: nxt = (opnd > cur) ? opnd : cur;
         OP_XCHG: nxt = opnd;
         OP_AND:  nxt = cur & opnd;
         OP_OR:   nxt = cur | opnd;
         OP_XOR:  nxt = cur ^ opnd;
         default: nxt = cur;
      endcase
   end
endmodule

// File: rtl/wac_group_pick.sv
module wac_group_pick #(
   parameter int LANES = 32,
   parameter int AW    = 32
) (
   input  logic [LANES-1:0]    pending,
   input  logic [LANES*AW-1:0] addr_flat,
   output logic                any,
   output logic [LANES-1:0]    members,
   output logic [AW-1:0]       lead_addr
);
   always_comb begin
      any       = 1'b0;
      lead_addr = '0;
      for (int i = 0; i < LANES; i++) begin
         if (!any && pending[i]) begin
            any       = 1'b1;
            lead_addr = addr_flat[i*AW +: AW];
         end
      end
      for (int i = 0; i < LANES; i++) begin
         members[i] = pending[i] && (addr_flat[i*AW +: AW] == lead_addr);
      end
   end
endmodule

// File: rtl/wac_slot.sv
module wac_slot #(
   parameter int LANES = 32,
   parameter int AW    = 32,
   parameter int DW    = 32,
   localparam int LIDX = $clog2(LANES)
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                start,
   input  logic [LANES-1:0]    start_mask,
   input  logic [AW-1:0]       start_addr,
   input  logic [LANES*3-1:0]  op_flat,
   input  logic [LANES*DW-1:0] data_flat,
   input  logic                mem_rvalid,
   input  logic [DW-1:0]       mem_rdata,
   input  logic                mem_wack,
   output logic                idle,
   output logic                mem_rd_en,
   output logic                mem_wr_en,
   output logic [AW-1:0]       mem_addr,
   output logic [DW-1:0]       mem_wdata,
   output logic                rsp_we,
   output logic [LIDX-1:0]     rsp_lane,
   output logic [DW-1:0]       rsp_val
);
   import wac_pkg::*;

   wac_slot_st_e     state;
   logic [LANES-1:0] mask;
   logic [AW-1:0]    addr;
   logic [DW-1:0]    acc;
   logic [LANES-1:0] low_bit;
   logic [LIDX-1:0]  cur_lane;
   logic             last;
   logic [DW-1:0]    nxt;

   always_comb begin
      low_bit  = mask & (~mask + LANES'(1));
      cur_lane = '0;
      for (int i = 0; i < LANES; i++) begin
         if (low_bit[i]) cur_lane = LIDX'(i);
      end
      last = ((mask & ~low_bit) == '0);
   end

   wac_alu #(.DW(DW)) u_alu (
      .op   (op_flat[int'(cur_lane)*3 +: 3]),
      .cur  (acc),
      .opnd (data_flat[int'(cur_lane)*DW +: DW]),
      .nxt  (nxt)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state <= S_IDLE;
         mask  <= '0;
         addr  <= '0;
         acc   <= '0;
      end else begin
         unique case (state)
            S_IDLE: if (start) begin
               mask  <= start_mask;
               addr  <= start_addr;
               state <= S_RREQ;
            end
            S_RREQ:  state <= S_RWAIT;
            S_RWAIT: if (mem_rvalid) begin
               acc   <= mem_rdata;
               state <= S_UPD;
            end
            S_UPD: begin
               acc  <= nxt;
               mask <= mask & ~low_bit;
               if (last) state <= S_WREQ;
            end
            S_WREQ:  state <= S_WWAIT;
            S_WWAIT: if (mem_wack) state <= S_IDLE;
            default: state <= S_IDLE;
         endcase
      end
   end

   assign idle      = (state == S_IDLE);
   assign mem_rd_en = (state == S_RREQ);
   assign mem_wr_en = (state == S_WREQ);
   assign mem_addr  = addr;
   assign mem_wdata = acc;
   assign rsp_we    = (state == S_UPD);
   assign rsp_lane  = cur_lane;
   assign rsp_val   = acc;
endmodule

// File: rtl/warp_atomic_combiner.sv
module warp_atomic_combiner #(
   parameter int LANES = 32,
   parameter int SLOTS = 2,
   parameter int AW    = 32,
   parameter int DW    = 32,
   localparam int LIDX = $clog2(LANES)
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                req_valid,
   output logic                req_ready,
   input  logic [LANES-1:0]    req_lane_valid,
   input  logic [LANES*AW-1:0] req_addr,
   input  logic [LANES*3-1:0]  req_op,
   input  logic [LANES*DW-1:0] req_data,
   output logic                rsp_valid,
   input  logic                rsp_ready,
   output logic [LANES*DW-1:0] rsp_data,
   output logic [SLOTS-1:0]    mem_rd_en,
   output logic [SLOTS-1:0]    mem_wr_en,
   output logic [SLOTS*AW-1:0] mem_addr,
   output logic [SLOTS*DW-1:0] mem_wdata,
   input  logic [SLOTS-1:0]    mem_rvalid,
   input  logic [SLOTS*DW-1:0] mem_rdata,
   input  logic [SLOTS-1:0]    mem_wack
);
   if (LANES < 2 || SLOTS < 1 || AW < 1 || DW < 1) begin : g_bad_cfg
      $error("warp_atomic_combiner: LANES>=2, SLOTS>=1, AW>=1, DW>=1 required");
   end

   logic                busy, done;
   logic [LANES-1:0]    pending;
   logic [LANES*AW-1:0] addr_q;
   logic [LANES*3-1:0]  op_q;
   logic [LANES*DW-1:0] data_q;
   logic [LANES*DW-1:0] rsp_q;

   logic                pick_any;
   logic [LANES-1:0]    pick_members;
   logic [AW-1:0]       pick_addr;
   logic [SLOTS-1:0]    slot_idle, slot_start, slot_rsp_we;
   logic [LIDX-1:0]     slot_lane [SLOTS];
   logic [DW-1:0]       slot_val  [SLOTS];
   logic                granted;

   wac_group_pick #(.LANES(LANES), .AW(AW)) u_pick (
      .pending   (pending),
      .addr_flat (addr_q),
      .any       (pick_any),
      .members   (pick_members),
      .lead_addr (pick_addr)
   );

   always_comb begin
      slot_start = '0;
      granted    = 1'b0;
      for (int s = 0; s < SLOTS; s++) begin
         if (!granted && slot_idle[s] && busy && !done && pick_any) begin
            granted       = 1'b1;
            slot_start[s] = 1'b1;
         end
      end
   end

   for (genvar s = 0; s < SLOTS; s++) begin : g_slot
      wac_slot #(.LANES(LANES), .AW(AW), .DW(DW)) u_slot (
         .clk        (clk),
         .rst_n      (rst_n),
         .start      (slot_start[s]),
         .start_mask (pick_members),
         .start_addr (pick_addr),
         .op_flat    (op_q),
         .data_flat  (data_q),
         .mem_rvalid (mem_rvalid[s]),
         .mem_rdata  (mem_rdata[s*DW +: DW]),
         .mem_wack   (mem_wack[s]),
         .idle       (slot_idle[s]),
         .mem_rd_en  (mem_rd_en[s]),
         .mem_wr_en  (mem_wr_en[s]),
         .mem_addr   (mem_addr[s*AW +: AW]),
         .mem_wdata  (mem_wdata[s*DW +: DW]),
         .rsp_we     (slot_rsp_we[s]),
         .rsp_lane   (slot_lane[s]),
         .rsp_val    (slot_val[s])
      );
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy    <= 1'b0;
         done    <= 1'b0;
         pending <= '0;
         addr_q  <= '0;
         op_q    <= '0;
         data_q  <= '0;
         rsp_q   <= '0;
      end else begin
         if (req_valid && !busy) begin
            busy    <= 1'b1;
            pending <= req_lane_valid;
            addr_q  <= req_addr;
            op_q    <= req_op;
            data_q  <= req_data;
            rsp_q   <= '0;
         end else if (busy) begin
            if (granted) pending <= pending & ~pick_members;
            if (!done && pending == '0 && &slot_idle) done <= 1'b1;
            if (done && rsp_ready) begin
               done <= 1'b0;
               busy <= 1'b0;
            end
            for (int s = 0; s < SLOTS; s++) begin
               if (slot_rsp_we[s]) rsp_q[int'(slot_lane[s])*DW +: DW] <= slot_val[s];
            end
         end
      end
   end

   assign req_ready = !busy;
   assign rsp_valid = done;
   assign rsp_data  = rsp_q;
endmodule

// File: rtl/wac_checker.sv
module wac_checker #(
   parameter int LANES = 32,
   parameter int SLOTS = 2,
   parameter int AW    = 32,
   parameter int DW    = 32
) (
   input logic                clk,
   input logic                rst_n,
   input logic                req_valid,
   input logic                req_ready,
   input logic [LANES-1:0]    req_lane_valid,
   input logic                rsp_valid,
   input logic                rsp_ready,
   input logic [LANES*DW-1:0] rsp_data,
   input logic [SLOTS-1:0]    mem_rd_en,
   input logic [SLOTS-1:0]    mem_wr_en,
   input logic [SLOTS*AW-1:0] mem_addr
);
   logic [SLOTS-1:0] open;
   int unsigned      wr_cnt, lane_cnt;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         open     <= '0;
         wr_cnt   <= 0;
         lane_cnt <= 0;
      end else begin
         for (int s = 0; s < SLOTS; s++) begin
            if (mem_rd_en[s]) open[s] <= 1'b1;
            else if (mem_wr_en[s]) open[s] <= 1'b0;
         end
         if (req_valid && req_ready) begin
            wr_cnt   <= 0;
            lane_cnt <= $countones(req_lane_valid);
         end else begin
            wr_cnt <= wr_cnt + $countones(mem_wr_en);
         end
      end
   end

   AST_NO_ACCEPT_WHILE_DONE: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |-> !req_ready);  // R1
   AST_RSP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_data));  // R8
   AST_IDLE_NO_MEM: assert property (@(posedge clk) disable iff (!rst_n)
      req_ready |-> (mem_rd_en == '0 && mem_wr_en == '0));  // R9
   AST_WRITE_BUDGET: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |-> wr_cnt <= lane_cnt);  // R4

   for (genvar s = 0; s < SLOTS; s++) begin : g_s
      AST_WRITE_AFTER_READ: assert property (@(posedge clk) disable iff (!rst_n)
         mem_wr_en[s] |-> open[s]);  // R4
      AST_ONE_READ: assert property (@(posedge clk) disable iff (!rst_n)
         mem_rd_en[s] |-> !open[s]);  // R4
      for (genvar t = s + 1; t < SLOTS; t++) begin : g_t
         AST_DISJOINT_WRITES: assert property (@(posedge clk) disable iff (!rst_n)
            mem_wr_en[s] && mem_wr_en[t] |-> mem_addr[s*AW +: AW] != mem_addr[t*AW +: AW]);  // R4
      end
   end
endmodule

bind warp_atomic_combiner wac_checker #(.LANES(LANES), .SLOTS(SLOTS), .AW(AW), .DW(DW)) u_chk (
   .clk            (clk),
   .rst_n          (rst_n),
   .req_valid      (req_valid),
   .req_ready      (req_ready),
   .req_lane_valid (req_lane_valid),
   .rsp_valid      (rsp_valid),
   .rsp_ready      (rsp_ready),
   .rsp_data       (rsp_data),
   .mem_rd_en      (mem_rd_en),
   .mem_wr_en      (mem_wr_en),
   .mem_addr       (mem_addr)
);

// File: tb/warp_atomic_combiner_test.sv
module warp_atomic_combiner_test;
   localparam int LANES = 32;
   localparam int SLOTS = 2;
   localparam int AW    = 8;
   localparam int DW    = 32;
   localparam int LAT   = 3;
   localparam int WORDS = 1 << AW;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic req_valid = 1'b0;
   logic rsp_ready = 1'b0;
   logic req_ready, rsp_valid;
   logic [LANES-1:0]    req_lane_valid = '0;
   logic [LANES*AW-1:0] req_addr = '0;
   logic [LANES*3-1:0]  req_op = '0;
   logic [LANES*DW-1:0] req_data = '0;
   logic [LANES*DW-1:0] rsp_data;
   logic [SLOTS-1:0]    mem_rd_en, mem_wr_en;
   logic [SLOTS*AW-1:0] mem_addr;
   logic [SLOTS*DW-1:0] mem_wdata;
   logic [SLOTS-1:0]    mem_rvalid;
   logic [SLOTS*DW-1:0] mem_rdata;
   logic [SLOTS-1:0]    mem_wack;

   always #5 clk = ~clk;

   warp_atomic_combiner #(.LANES(LANES), .SLOTS(SLOTS), .AW(AW), .DW(DW)) uut (.*);

   logic [DW-1:0] mem  [WORDS];
   logic [DW-1:0] refm [WORDS];
   int  rd_cnt [SLOTS];
   int  wk_cnt [SLOTS];
   logic [AW-1:0] rd_a [SLOTS];
   bit  active [SLOTS];
   int  wr_count;
   bit  overlap_seen;
   int  checks = 0, fails = 0;
   int  cycles = 0;

   always @(posedge clk) begin
      cycles++;
      if (!rst_n) begin
         mem_rvalid <= '0;
         mem_wack   <= '0;
         mem_rdata  <= '0;
         for (int s = 0; s < SLOTS; s++) begin
            rd_cnt[s] = 0; wk_cnt[s] = 0; active[s] = 0;
         end
      end else begin
         for (int s = 0; s < SLOTS; s++) begin
            mem_rvalid[s] <= 1'b0;
            mem_wack[s]   <= 1'b0;
            if (rd_cnt[s] > 0) begin
               rd_cnt[s]--;
               if (rd_cnt[s] == 0) begin
                  mem_rvalid[s] <= 1'b1;
                  mem_rdata[s*DW +: DW] <= mem[rd_a[s]];
               end
            end
            if (wk_cnt[s] > 0) begin
               wk_cnt[s]--;
               if (wk_cnt[s] == 0) begin
                  mem_wack[s] <= 1'b1;
                  active[s] = 0;
               end
            end
            if (mem_rd_en[s]) begin
               rd_cnt[s] = LAT - 1;
               rd_a[s]   = mem_addr[s*AW +: AW];
               active[s] = 1;
               if (LAT - 1 == 0) begin
                  mem_rvalid[s] <= 1'b1;
                  mem_rdata[s*DW +: DW] <= mem[rd_a[s]];
               end
            end
            if (mem_wr_en[s]) begin
               mem[mem_addr[s*AW +: AW]] = mem_wdata[s*DW +: DW];
               wr_count++;
               wk_cnt[s] = LAT;
            end
         end
         if (active[0] && active[1]) overlap_seen = 1;
      end
   end

   function automatic logic [DW-1:0] alu_ref(logic [2:0] op, logic [DW-1:0] c, logic [DW-1:0] d);
      case (op)
         3'd0: return c + d;
         3'd1: return (d < c) ? d : c;
         3'd2: return (d > c) ? d : c;
         3'd3: return d;
         3'd4: return c & d;
         3'd5: return c | d;
         3'd6: return c ^ d;
         default: return c;
      endcase
   endfunction

   task automatic check(string req, string what, logic [DW-1:0] act, logic [DW-1:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   bit            lv [LANES];
   logic [AW-1:0] ad [LANES];
   logic [2:0]    op [LANES];
   logic [DW-1:0] dt [LANES];

   task automatic run_batch(string name, string req_rsp, bit want_overlap);
      logic [DW-1:0] exp_rsp [LANES];
      bit seen [WORDS];
      int exp_wr = 0;
      for (int w = 0; w < WORDS; w++) seen[w] = 0;
      for (int i = 0; i < LANES; i++) begin
         exp_rsp[i] = '0;
         if (lv[i]) begin
            exp_rsp[i]  = refm[ad[i]];
            refm[ad[i]] = alu_ref(op[i], refm[ad[i]], dt[i]);
            if (!seen[ad[i]]) begin seen[ad[i]] = 1; exp_wr++; end
         end
      end
      @(negedge clk);
      for (int i = 0; i < LANES; i++) begin
         req_lane_valid[i]        = lv[i];
         req_addr[i*AW +: AW]     = ad[i];
         req_op[i*3 +: 3]         = op[i];
         req_data[i*DW +: DW]     = dt[i];
      end
      req_valid = 1'b1;
      while (!req_ready && cycles < 150000) @(negedge clk);
      wr_count = 0;
      overlap_seen = 0;
      @(negedge clk);
      req_valid = 1'b0;
      check("R1", {name, " ready low while busy"}, DW'(req_ready), DW'(0));
      while (!rsp_valid && cycles < 150000) @(negedge clk);
      begin
         logic [LANES*DW-1:0] first = rsp_data;
         @(negedge clk);
         @(negedge clk);
         check("R8", {name, " valid held"}, DW'(rsp_valid), DW'(1));
         check("R8", {name, " data stable"}, DW'(rsp_data == first), DW'(1));
      end
      for (int i = 0; i < LANES; i++)
         check(lv[i] ? req_rsp : "R7", $sformatf("%s lane %0d", name, i),
               rsp_data[i*DW +: DW], exp_rsp[i]);
      rsp_ready = 1'b1;
      @(negedge clk);
      rsp_ready = 1'b0;
      check("R1", {name, " ready back"}, DW'(req_ready), DW'(1));
      check("R4", {name, " write count"}, DW'(wr_count), DW'(exp_wr));
      begin
         int bad = 0;
         for (int w = 0; w < WORDS; w++) if (mem[w] !== refm[w]) bad++;
         check("R5", {name, " memory image mismatches"}, DW'(bad), DW'(0));
      end
      if (want_overlap) check("R6", {name, " slots overlapped"}, DW'(overlap_seen), DW'(1));
   endtask

   initial begin
      void'($urandom(32'h5eed_1234));
      for (int w = 0; w < WORDS; w++) begin
         mem[w]  = $urandom;
         refm[w] = mem[w];
      end
      repeat (3) @(negedge clk);
      check("R1", "reset ready", DW'(req_ready), DW'(1));
      check("R1", "reset rsp_valid", DW'(rsp_valid), DW'(0));
      rst_n = 1'b1;
      @(negedge clk);

      // R2 R4: full contention, add
      for (int i = 0; i < LANES; i++) begin lv[i] = 1; ad[i] = 8'd5; op[i] = 3'd0; dt[i] = DW'(i + 1); end
      run_batch("contention", "R2", 0);

      // R6: all distinct, xor
      for (int i = 0; i < LANES; i++) begin lv[i] = 1; ad[i] = AW'(100 + i); op[i] = 3'd6; dt[i] = $urandom; end
      run_batch("distinct", "R2", 1);

      // R3: every opcode on one address
      for (int i = 0; i < LANES; i++) begin lv[i] = 1; ad[i] = 8'd9; op[i] = 3'(i % 8); dt[i] = $urandom; end
      run_batch("opcodes", "R3", 0);

      // R3: opcodes across two addresses with small operands for min/max
      for (int i = 0; i < LANES; i++) begin lv[i] = 1; ad[i] = AW'(20 + (i % 2)); op[i] = 3'((i / 2) % 8); dt[i] = $urandom % 64; end
      run_batch("opcodes2", "R3", 0);

      // R7: odd lanes invalid, pointed at a word the valid lanes do not touch
      for (int i = 0; i < LANES; i++) begin
         lv[i] = (i % 2 == 0); ad[i] = (i % 2 == 0) ? AW'(30 + i % 3) : 8'd200;
         op[i] = 3'd3; dt[i] = $urandom;
      end
      run_batch("partial", "R2", 0);

      // R7: empty batch
      for (int i = 0; i < LANES; i++) begin lv[i] = 0; ad[i] = 8'd1; op[i] = 3'd0; dt[i] = 32'hFFFF; end
      run_batch("empty", "R2", 0);

      // R9: idle interval issues nothing
      wr_count = 0;
      repeat (10) @(negedge clk);
      check("R9", "idle writes", DW'(wr_count), DW'(0));

      // random mixed batches
      for (int b = 0; b < 20; b++) begin
         for (int i = 0; i < LANES; i++) begin
            lv[i] = ($urandom % 8) != 0;
            ad[i] = AW'($urandom % 8);
            op[i] = 3'($urandom % 8);
            dt[i] = ($urandom % 2) ? $urandom : DW'($urandom % 16);
         end
         run_batch($sformatf("random%0d", b), "R2", 0);
      end

      if (cycles >= 150000) begin
         fails++;
         $display("FAIL watchdog: actual %0d cycles expected < 150000", cycles);
      end
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      #1600000;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end
endmodule